// File: doc/BRIEF.md
# Calibration Coefficient Register Bank

This block holds the correction coefficients that a converter's calibration datapath applies to every raw result. It keeps one shared offset and gain pair that applies to all channels, and eight per-channel offset and gain pairs. Each coefficient is 24 bits wide. The pair that belongs to the channel code of the current conversion is driven continuously onto the coefficient outputs. The shared pair is always driven as well.

A host reaches every coefficient through a plain address, write-data and write-strobe port, and can read any of them at any time through a combinational read-data output. The bank does not stall the host: every strobe is decided in the cycle it arrives. A host write is stored only when the converter's 3-bit mode field reads idle and no internal update arrives in the same cycle. Any other host write is dropped, and a one-cycle reject pulse reports it.

The calibration engines load their results through a separate update port. That port bypasses the mode lockout and takes priority over the host. A self calibration writes the shared pair. A system calibration writes the selected channel's pair.

Top module: `calcoef_bank`

## Requirements
- R1: After reset, both shared coefficients read 0x800000, every per-channel gain reads 0x200000 and every per-channel offset reads 0x000000.
- R2: A host write strobed while `mode` is 3'b000 and `upd_valid` is low is stored, and its value reads back from the same address in the next cycle. The address map is: 0 = shared offset, 1 = shared gain, 8+c = channel c offset, 16+c = channel c gain.
- R3: A host write strobed while `mode` is not 3'b000 leaves every coefficient unchanged.
- R4: `host_wr_rej` is high for exactly the one cycle after a dropped host write strobe, and it stays low after an accepted write.
- R5: Every value stored into a per-channel offset, from either port, has bit 22 cleared. The other bits are kept.
- R6: An update of kind 2'b10 (system zero-scale) writes `upd_data` into the offset of channel `sel_chan` only.
- R7: An update of kind 2'b11 (system full-scale) writes `upd_data` into the gain of channel `sel_chan` only.
- R8: An update of kind 2'b00 (self zero-scale) writes the shared offset, and an update of kind 2'b01 (self full-scale) writes the shared gain.
- R9: Updates are stored whatever the value of `mode`, and they never raise `host_wr_rej` on their own.
- R10: When a host write and an update arrive in the same cycle, the update is stored and the host write is dropped and flagged as in R4.
- R11: `coef_ch_off` and `coef_ch_gain` show the pair of channel `sel_chan`, and `coef_sh_off` and `coef_sh_gain` show the shared pair. All four follow `sel_chan` combinationally.
- R12: Addresses outside the map in R2 read as zero. An idle-mode write to such an address changes nothing and is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Converter mode field; 3'b000 means idle |
| sel_chan | input | 3 | Channel code of the current conversion |
| host_addr | input | 5 | Host register address for reads and writes |
| host_wdata | input | 24 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rdata | output | 24 | Coefficient at `host_addr`, combinational |
| host_wr_rej | output | 1 | Pulse, one cycle after a dropped host write |
| upd_valid | input | 1 | Calibration engine update strobe |
| upd_kind | input | 2 | Update target: 00 self ZS, 01 self FS, 10 system ZS, 11 system FS |
| upd_data | input | 24 | Coefficient value from the calibration engine |
| coef_sh_off | output | 24 | Shared offset coefficient |
| coef_sh_gain | output | 24 | Shared gain coefficient |
| coef_ch_off | output | 24 | Offset coefficient of channel `sel_chan` |
| coef_ch_gain | output | 24 | Gain coefficient of channel `sel_chan` |

## Verification
A host write and an engine update can land on the same clock edge, and the arbitration between them is the behaviour most likely to go wrong. The bench raises `host_wr` and `upd_valid` together, with the two strobes aimed at different registers. Readback then has to show the update stored and the host's target unchanged. The reject pulse has to appear in the following cycle and clear one cycle after that. The lockout is also judged separately by mode, with no update present, so that a drop caused by a collision is not confused with a drop caused by a busy converter.

// File: rtl/calcoef_pkg.sv
package calcoef_pkg;

  typedef enum logic [1:0] {
    UPD_SELF_ZS = 2'b00,
    UPD_SELF_FS = 2'b01,
    UPD_SYS_ZS  = 2'b10,
    UPD_SYS_FS  = 2'b11
  } upd_kind_e;

  // one-hot-or-none selection of the register class being written
  typedef struct packed {
    logic sh_off;
    logic sh_gain;
    logic ch_off;
    logic ch_gain;
  } wr_sel_t;

  // address regions, taken from the bits above the channel index
  localparam logic [1:0] REG_SHARED = 2'd0;
  localparam logic [1:0] REG_CH_OFF = 2'd1;
  localparam logic [1:0] REG_CH_GN  = 2'd2;

endpackage

// File: rtl/calcoef_wr_arb.sv
module calcoef_wr_arb
  import calcoef_pkg::*;
#(
  parameter int W      = 24,
  parameter int CH_W   = 3,
  parameter int MODE_W = 3,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  input  logic              host_wr,
  input  logic              upd_valid,
  input  logic [1:0]        upd_kind,
  input  logic [W-1:0]      upd_data,
  output wr_sel_t           wr_sel,
  output logic [CH_W-1:0]   wr_ch,
  output logic [W-1:0]      wr_data,
  output logic              host_rej
);

  logic            idle;
  logic            host_ok;
  logic [1:0]      region;
  logic [CH_W-1:0] idx;
  upd_kind_e       kind;

  assign idle    = (mode == '0);
  assign host_ok = host_wr && idle && !upd_valid;
  assign region  = host_addr[ADDR_W-1:CH_W];
  assign idx     = host_addr[CH_W-1:0];
  assign kind    = upd_kind_e'(upd_kind);

  always_comb begin
    wr_sel  = '0;
    wr_ch   = sel_chan;
    wr_data = upd_data;
    if (upd_valid) begin
      unique case (kind)
        UPD_SELF_ZS: wr_sel.sh_off  = 1'b1;
        UPD_SELF_FS: wr_sel.sh_gain = 1'b1;
        UPD_SYS_ZS:  wr_sel.ch_off  = 1'b1;
        UPD_SYS_FS:  wr_sel.ch_gain = 1'b1;
      endcase
    end else if (host_ok) begin
      wr_data = host_wdata;
      wr_ch   = idx;
      case (region)
        REG_SHARED: begin
          if (idx == CH_W'(0)) wr_sel.sh_off  = 1'b1;
          if (idx == CH_W'(1)) wr_sel.sh_gain = 1'b1;
        end
        REG_CH_OFF: wr_sel.ch_off  = 1'b1;
        REG_CH_GN:  wr_sel.ch_gain = 1'b1;
        default: ;
      endcase
    end
  end

  // dropped host strobe -> one-cycle flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rej <= 1'b0;
    else        host_rej <= host_wr && (!idle || upd_valid);
  end

  p_rej_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rej |-> ($past(host_wr) && ($past(mode) != '0 || $past(upd_valid))));

  p_locked_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !idle && !upd_valid) |-> (wr_sel == '0));

  p_update_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && upd_valid) |-> (wr_data == upd_data && $countones(wr_sel) == 1));

endmodule

// File: rtl/calcoef_store.sv
module calcoef_store
  import calcoef_pkg::*;
#(
  parameter int W      = 24,
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  wr_sel_t                     wr_sel,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic [W-1:0]                wr_data,
  output logic [W-1:0]                sh_off_q,
  output logic [W-1:0]                sh_gain_q,
  output logic [NUM_CH-1:0][W-1:0]    ch_off_q,
  output logic [NUM_CH-1:0][W-1:0]    ch_gain_q
);

  localparam logic [W-1:0] SH_DEFAULT = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] GN_DEFAULT = {3'b001, {(W-3){1'b0}}};
  localparam logic [W-1:0] OFS_MASK   = ~{2'b01, {(W-2){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_off_q  <= SH_DEFAULT;
      sh_gain_q <= SH_DEFAULT;
    end else begin
      if (wr_sel.sh_off)  sh_off_q  <= wr_data;
      if (wr_sel.sh_gain) sh_gain_q <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_off_q[c]  <= '0;
        ch_gain_q[c] <= GN_DEFAULT;
      end else if (wr_ch == CH_W'(c)) begin
        if (wr_sel.ch_off)  ch_off_q[c]  <= wr_data & OFS_MASK;
        if (wr_sel.ch_gain) ch_gain_q[c] <= wr_data;
      end
    end

    p_ofs_bit22_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_off_q[c][W-2] == 1'b0);
  end

endmodule

// File: rtl/calcoef_bank.sv
module calcoef_bank
  import calcoef_pkg::*;
#(
  parameter int   COEF_W = 24,
  parameter int   NUM_CH = 8,
  parameter int   MODE_W = 3,
  localparam int  CH_W   = $clog2(NUM_CH),
  localparam int  ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [COEF_W-1:0] host_wdata,
  input  logic              host_wr,
  output logic [COEF_W-1:0] host_rdata,
  output logic              host_wr_rej,
  input  logic              upd_valid,
  input  logic [1:0]        upd_kind,
  input  logic [COEF_W-1:0] upd_data,
  output logic [COEF_W-1:0] coef_sh_off,
  output logic [COEF_W-1:0] coef_sh_gain,
  output logic [COEF_W-1:0] coef_ch_off,
  output logic [COEF_W-1:0] coef_ch_gain
);

  localparam logic [COEF_W-1:0] OFS_MASK = ~{2'b01, {(COEF_W-2){1'b0}}};

  wr_sel_t                        wr_sel;
  logic [CH_W-1:0]                wr_ch;
  logic [COEF_W-1:0]              wr_data;
  logic [COEF_W-1:0]              sh_off_q, sh_gain_q;
  logic [NUM_CH-1:0][COEF_W-1:0]  ch_off_q, ch_gain_q;
  logic [1:0]                     rd_region;
  logic [CH_W-1:0]                rd_idx;

  calcoef_wr_arb #(
    .W(COEF_W), .CH_W(CH_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)
  ) arb_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel_chan(sel_chan),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
    .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_data(upd_data),
    .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data), .host_rej(host_wr_rej)
  );

  calcoef_store #(
    .W(COEF_W), .NUM_CH(NUM_CH), .CH_W(CH_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
    .sh_off_q(sh_off_q), .sh_gain_q(sh_gain_q),
    .ch_off_q(ch_off_q), .ch_gain_q(ch_gain_q)
  );

  // host read path, combinational on the address
  assign rd_region = host_addr[ADDR_W-1:CH_W];
  assign rd_idx    = host_addr[CH_W-1:0];

  always_comb begin
    host_rdata = '0;
    case (rd_region)
      REG_SHARED: begin
        if (rd_idx == CH_W'(0)) host_rdata = sh_off_q;
        if (rd_idx == CH_W'(1)) host_rdata = sh_gain_q;
      end
      REG_CH_OFF: host_rdata = ch_off_q[rd_idx];
      REG_CH_GN:  host_rdata = ch_gain_q[rd_idx];
      default: ;
    endcase
  end

  // coefficients toward the datapath
  assign coef_sh_off  = sh_off_q;
  assign coef_sh_gain = sh_gain_q;
  assign coef_ch_off  = ch_off_q[sel_chan];
  assign coef_ch_gain = ch_gain_q[sel_chan];

  p_locked_shared_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && mode != '0) |=> ($stable(coef_sh_off) && $stable(coef_sh_gain)));

  p_sys_zs_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_kind == UPD_SYS_ZS) |=>
      (sel_chan != $past(sel_chan) || coef_ch_off == ($past(upd_data) & OFS_MASK)));

  p_sys_fs_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_kind == UPD_SYS_FS) |=>
      (sel_chan != $past(sel_chan) || coef_ch_gain == $past(upd_data)));

  p_self_fs_any_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_kind == UPD_SELF_FS) |=> (coef_sh_gain == $past(upd_data)));

endmodule

// File: tb/calcoef_bank_tb.sv
module calcoef_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  sel_chan = '0;
  logic [4:0]  host_addr = '0;
  logic [23:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic [23:0] host_rdata;
  logic        host_wr_rej;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_kind = '0;
  logic [23:0] upd_data = '0;
  logic [23:0] coef_sh_off, coef_sh_gain, coef_ch_off, coef_ch_gain;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  calcoef_bank dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel_chan(sel_chan),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_wr_rej(host_wr_rej),
    .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_data(upd_data),
    .coef_sh_off(coef_sh_off), .coef_sh_gain(coef_sh_gain),
    .coef_ch_off(coef_ch_off), .coef_ch_gain(coef_ch_gain)
  );

  // {mode[56:54], addr[53:49], wdata[48:25], expected readback[24:1], expected reject[0]}
  localparam logic [56:0] VEC [12] = '{
    {3'd0, 5'd0,  24'h123456, 24'h123456, 1'b0},  // R2 shared offset
    {3'd1, 5'd0,  24'hABCDEF, 24'h123456, 1'b1},  // R3 R4 locked
    {3'd0, 5'd1,  24'h900000, 24'h900000, 1'b0},  // R2 shared gain
    {3'd4, 5'd1,  24'h111111, 24'h900000, 1'b1},  // R3 R4
    {3'd0, 5'd8,  24'h8F4240, 24'h8F4240, 1'b0},  // R2 ch0 offset
    {3'd0, 5'd9,  24'hC00001, 24'h800001, 1'b0},  // R5 bit 22 cleared
    {3'd0, 5'd23, 24'hFFFFFF, 24'hFFFFFF, 1'b0},  // R2 ch7 gain
    {3'd7, 5'd23, 24'h000001, 24'hFFFFFF, 1'b1},  // R3 R4
    {3'd0, 5'd24, 24'h555555, 24'h000000, 1'b0},  // R12 unmapped
    {3'd0, 5'd2,  24'h777777, 24'h000000, 1'b0},  // R12 unmapped in shared region
    {3'd2, 5'd24, 24'h000001, 24'h000000, 1'b1},  // R4 locked strobe flagged
    {3'd0, 5'd16, 24'h280000, 24'h280000, 1'b0}   // R2 ch0 gain
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [23:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic host_write(input logic [2:0] m, input logic [4:0] a, input logic [23:0] d);
    mode = m; host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic update(input logic [1:0] k, input logic [23:0] d);
    upd_valid = 1'b1; upd_kind = k; upd_data = d;
    @(posedge clk); @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values over the whole map
    rd(5'd0, v); check("R1 shared offset", v, 24'h800000);
    rd(5'd1, v); check("R1 shared gain", v, 24'h800000);
    for (int c = 0; c < 8; c++) begin
      rd(5'(8 + c), v);  check("R1 channel offset", v, 24'h000000);
      rd(5'(16 + c), v); check("R1 channel gain", v, 24'h200000);
    end
    check("R4 no flag after reset", {23'd0, host_wr_rej}, 24'd0);

    // table of host writes: readback and reject flag
    for (int i = 0; i < 12; i++) begin
      host_write(VEC[i][56:54], VEC[i][53:49], VEC[i][48:25]);
      check("R4 reject flag", {23'd0, host_wr_rej}, {23'd0, VEC[i][0]});
      rd(VEC[i][53:49], v);
      check("R2/R3/R5/R12 readback", v, VEC[i][24:1]);
    end
    @(negedge clk);
    check("R4 flag lasts one cycle", {23'd0, host_wr_rej}, 24'd0);

    // R11 selected pair on the coefficient outputs
    sel_chan = 3'd0; #1;
    check("R11 ch0 offset out", coef_ch_off, 24'h8F4240);
    check("R11 ch0 gain out", coef_ch_gain, 24'h280000);
    sel_chan = 3'd1; #1;
    check("R11 ch1 offset out", coef_ch_off, 24'h800001);
    check("R11 ch1 gain out", coef_ch_gain, 24'h200000);
    check("R11 shared offset out", coef_sh_off, 24'h123456);
    check("R11 shared gain out", coef_sh_gain, 24'h900000);

    // R6 R9 system zero-scale in busy mode
    mode = 3'd1; sel_chan = 3'd3;
    update(2'b10, 24'h400010);
    check("R9 update raises no flag", {23'd0, host_wr_rej}, 24'd0);
    rd(5'd11, v); check("R6 ch3 offset, R5 bit 22 cleared", v, 24'h000010);
    rd(5'd10, v); check("R6 ch2 offset untouched", v, 24'h000000);
    rd(5'd19, v); check("R6 ch3 gain untouched", v, 24'h200000);

    // R7 system full-scale
    mode = 3'd4; sel_chan = 3'd5;
    update(2'b11, 24'h123000);
    rd(5'd21, v); check("R7 ch5 gain", v, 24'h123000);
    rd(5'd20, v); check("R7 ch4 gain untouched", v, 24'h200000);
    rd(5'd13, v); check("R7 ch5 offset untouched", v, 24'h000000);

    // R8 self calibrations
    mode = 3'd2;
    update(2'b00, 24'h7FFFFE);
    rd(5'd0, v); check("R8 self ZS shared offset", v, 24'h7FFFFE);
    update(2'b01, 24'h812345);
    rd(5'd1, v); check("R8 self FS shared gain", v, 24'h812345);
    rd(5'd0, v); check("R8 shared offset kept", v, 24'h7FFFFE);

    // R10 collision: host aims at shared gain, update at shared offset
    mode = 3'd0;
    host_addr = 5'd1; host_wdata = 24'hAAAAAA; host_wr = 1'b1;
    upd_valid = 1'b1; upd_kind = 2'b00; upd_data = 24'h0F0F0F;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; upd_valid = 1'b0;
    check("R10 collision flagged", {23'd0, host_wr_rej}, 24'd1);
    rd(5'd0, v); check("R10 update stored", v, 24'h0F0F0F);
    rd(5'd1, v); check("R10 host write dropped", v, 24'h812345);
    @(negedge clk);
    check("R4 flag cleared after collision", {23'd0, host_wr_rej}, 24'd0);

    // R12 idle write to unmapped address leaves mapped registers alone
    host_write(3'd0, 5'd31, 24'h000123);
    check("R12 no flag for unmapped", {23'd0, host_wr_rej}, 24'd0);
    rd(5'd31, v); check("R12 unmapped reads zero", v, 24'h000000);
    rd(5'd23, v); check("R12 ch7 gain kept", v, 24'hFFFFFF);

    // R1 reset in mid-run
    rst_n = 1'b0; #1;
    rd(5'd1, v);  check("R1 shared gain after reset", v, 24'h800000);
    rd(5'd21, v); check("R1 ch5 gain after reset", v, 24'h200000);
    rd(5'd11, v); check("R1 ch3 offset after reset", v, 24'h000000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule